// File: doc/BRIEF.md
# Cycle-Stepped Packing DMA Channel

This block is one DMA channel that moves data through a single synchronous memory port, one bus operation per clock. A transfer is described by an internal index and modifier, an external index and modifier, a signed source word count, a packing mode and a direction bit. In each transfer step the channel reads one, two or six consecutive source words. It folds their low bits into one destination word, writes that word, and then moves both addresses and the count. When the count runs out, the channel can raise a completion interrupt and can fetch a further descriptor from internal memory, so that it goes on without help from the host.

A high level on the stall input freezes the whole channel, so that a slow downstream consumer can hold writes back. Memory reads return data one cycle after the request, so a multi-word step is spread over several sub-cycles. The states are `ST_IDLE`, `ST_FETCH`, `ST_DRAIN`, `ST_WRITE`, `ST_DFETCH`, `ST_DDRAIN` and `ST_DLOAD`, with these transitions:

- IDLE→FETCH on a direct start. IDLE→DFETCH on a chained start.
- FETCH→DRAIN after the last read of a step. DRAIN→WRITE.
- WRITE→FETCH while the count stays positive. WRITE→DFETCH at completion with a non-zero next pointer. WRITE→IDLE at completion with no next pointer.
- DFETCH→DDRAIN after the sixth descriptor read. DDRAIN→DLOAD. DLOAD→FETCH.

None of these transitions is taken while stall is high.

Top module: `pkdma_channel`

## Requirements
- R1: After reset, busy, err, irq_pend, every bit of irq_latch and mem_req are all 0.
- R2: Mode 0 (no packing): each step reads one word at the source and writes its bits 31:0, zero-extended, to the destination.
- R3: Mode 1 (16 into 32): each step reads source words s and s+1. It writes {s[15:0], (s+1)[15:0]} in bits 31:0, with bits 47:32 zero.
- R4: Mode 2 (8 into 48): each step reads words s to s+5. The low byte of word s+k lands in bits 8k+7:8k of the 48-bit destination word.
- R5: Each step takes N+2 cycles, where N is 1, 2 or 6 for modes 0, 1 and 2. Each step lowers the count by N. The transfer ends at the step that leaves the count at or below zero, and busy falls on the edge of that final write. A count of 7 in mode 2 gives two steps and 16 busy cycles.
- R6: After each step the source address moves by N times its signed modifier and the destination by its signed modifier, all modulo 2^AW.
- R7: With cfg_tx=1 the source is the internal side and the destination the external side; with cfg_tx=0 the roles swap. The internal address is the index masked to bits 16:0, with bit 17 forced to 1.
- R8: While stall is high, mem_req stays low and the state, addresses, count and flags hold. A start presented during stall is ignored.
- R9: At completion, when the interrupt is raised, bit CH+10 of irq_latch is set. irq_pend is set as well if irq_mask bit CH+10 is 1. A pulse on irq_clr clears both.
- R10: A start with non-zero bits 16:0 in cfg_chain fetches a six-word descriptor at base B = 0x20000 | chain[16:0], read downward: B internal index, B-1 internal modifier, B-2 count, B-3 next pointer, B-4 external index, B-5 external modifier. At completion, a non-zero next[16:0] loads the next descriptor in the same way.
- R11: A direct transfer always raises the interrupt. A descriptor-loaded transfer raises it only if bit 17 of its next pointer is 1.
- R12: A start with mode 3 sets err, leaves busy low and makes no memory access. The next start with a valid mode clears err.
- R13: A start that arrives while busy is high has no effect on the running transfer, and no memory location is written for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that launches a transfer when idle |
| cfg_mode | input | 2 | Packing mode: 0 word, 1 halves, 2 bytes, 3 invalid |
| cfg_tx | input | 1 | 1: internal to external, 0: external to internal |
| cfg_int_idx | input | AW | Internal index |
| cfg_int_mod | input | AW | Internal signed modifier |
| cfg_ext_idx | input | AW | External index |
| cfg_ext_mod | input | AW | External signed modifier |
| cfg_count | input | CW | Signed source word count |
| cfg_chain | input | AW | Initial chain pointer; zero in bits 16:0 selects a direct start |
| stall | input | 1 | Freezes all channel progress |
| irq_mask | input | IW | Interrupt mask vector |
| irq_clr | input | 1 | Clears this channel's latched and pending interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read request |
| busy | output | 1 | Channel active |
| err | output | 1 | Last start used an invalid mode |
| irq_latch | output | IW | Latched interrupt vector; only bit CH+10 is used |
| irq_pend | output | 1 | Masked completion interrupt pending |

## Verification
The assertions take for granted that mem_rdata carries the addressed word in the cycle after each read request. They also assume that stall and start are driven from the clock and are never unknown after reset. The bench memory model returns registered read data on exactly that schedule. The bench changes stall and start only on the falling edge. It keeps every random window, modifier and count small enough that internal and external addresses never alias in the model memory or run into the descriptor area.

// File: rtl/pkdma_pkg.sv
package pkdma_pkg;

    typedef enum logic [1:0] {
        MODE_WORD = 2'd0,
        MODE_HALF = 2'd1,
        MODE_BYTE = 2'd2,
        MODE_BAD  = 2'd3
    } pk_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_DRAIN  = 3'd2,
        ST_WRITE  = 3'd3,
        ST_DFETCH = 3'd4,
        ST_DDRAIN = 3'd5,
        ST_DLOAD  = 3'd6
    } pk_state_e;

    localparam int NSLOT      = 6;   // widest step and descriptor length
    localparam int SLOT_W     = 3;
    localparam int WIN_BIT    = 17;  // internal window select bit
    localparam int IRQ_OFFSET = 10;

    // source words consumed by one step of a given mode
    function automatic logic [SLOT_W-1:0] step_words(input pk_mode_e m);
        unique case (m)
            MODE_HALF: step_words = 3'd2;
            MODE_BYTE: step_words = 3'd6;
            default:   step_words = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/pkdma_gather.sv
module pkdma_gather #(
    parameter int DW     = 48,
    parameter int NSLOT  = 6,
    parameter int SW     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue,
    input  logic [SW-1:0]       slot,
    input  logic [DW-1:0]       rdata,
    output logic [NSLOT*DW-1:0] slots_flat
);

    // read data returns one cycle after issue; capture it even under stall
    logic          vld_q;
    logic [SW-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            slot_q <= '0;
        end else begin
            vld_q  <= issue;
            slot_q <= slot;
        end
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic [DW-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (vld_q && (slot_q == SW'(k))) begin
                word_q <= rdata;
            end
        end
        assign slots_flat[k*DW +: DW] = word_q;
    end

    // R4: a returning word always targets an existing slot
    a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (slot_q < SW'(NSLOT)));

endmodule

// File: rtl/pkdma_irq.sv
module pkdma_irq #(
    parameter int IW  = 32,
    parameter int BIT = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raise,
    input  logic          mask,
    input  logic          clr,
    output logic [IW-1:0] latch,
    output logic          pend
);

    logic lat_q;
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (raise) begin
            lat_q  <= 1'b1;
            pend_q <= pend_q | mask;
        end else if (clr) begin
            lat_q  <= 1'b0;
            pend_q <= 1'b0;
        end
    end

    for (genvar b = 0; b < IW; b++) begin : g_bit
        if (b == BIT) begin : g_live
            assign latch[b] = lat_q;
        end else begin : g_zero
            assign latch[b] = 1'b0;
        end
    end
    assign pend = pend_q;

    // R9: a pending interrupt is always also latched
    a_r9_pend_has_latch: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> latch[BIT]);
    // R9: the latch only drops through irq_clr
    a_r9_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (latch[BIT] && !clr) |=> latch[BIT]);

endmodule

// File: rtl/pkdma_channel.sv
module pkdma_channel
    import pkdma_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 48,
    parameter int CW = 16,
    parameter int IW = 32,
    parameter int CH = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_tx,
    input  logic [AW-1:0] cfg_int_idx,
    input  logic [AW-1:0] cfg_int_mod,
    input  logic [AW-1:0] cfg_ext_idx,
    input  logic [AW-1:0] cfg_ext_mod,
    input  logic [CW-1:0] cfg_count,
    input  logic [AW-1:0] cfg_chain,
    input  logic          stall,
    input  logic [IW-1:0] irq_mask,
    input  logic          irq_clr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          err,
    output logic [IW-1:0] irq_latch,
    output logic          irq_pend
);

    localparam int            IRQ_BIT  = CH + IRQ_OFFSET;
    localparam int            PW       = WIN_BIT + 1;
    localparam logic [AW-1:0] WIN_BASE = AW'(1) << WIN_BIT;
    localparam logic [SLOT_W-1:0] DLAST = SLOT_W'(NSLOT - 1);

    // ---------------- state and datapath registers ----------------
    pk_state_e                state_q, state_d;
    pk_mode_e                 mode_q;
    logic                     tx_q;
    logic                     chained_q;
    logic                     err_q;
    logic [AW-1:0]            src_q, dst_q, smod_q, dmod_q, dbase_q;
    logic signed [CW-1:0]     cnt_q;
    logic [PW-1:0]            chain_q;
    logic [SLOT_W-1:0]        sub_q;

    logic [NSLOT*DW-1:0]      slots_flat;
    logic [DW-1:0]            slot_w [NSLOT];
    logic [DW-1:0]            packed_w;

    for (genvar k = 0; k < NSLOT; k++) begin : g_unpack
        assign slot_w[k] = slots_flat[k*DW +: DW];
    end

    // ---------------- step arithmetic ----------------
    logic [SLOT_W-1:0]    nwords;
    logic                 last_sub;
    logic                 dlast_sub;
    logic signed [CW-1:0] cnt_next;
    logic                 step_done;
    logic                 more_desc;
    logic                 raise_irq;
    logic [AW-1:0]        src_step;
    logic                 start_ok;
    logic                 start_bad;
    logic                 start_chain;

    assign nwords    = step_words(mode_q);
    assign last_sub  = (sub_q == nwords - 3'd1);
    assign dlast_sub = (sub_q == DLAST);
    assign cnt_next  = cnt_q - CW'(nwords);
    assign step_done = (cnt_next <= 0);
    assign more_desc = (chain_q[WIN_BIT-1:0] != '0);

    assign start_ok    = start && !stall && (state_q == ST_IDLE);
    assign start_bad   = (pk_mode_e'(cfg_mode) == MODE_BAD);
    assign start_chain = (cfg_chain[WIN_BIT-1:0] != '0);

    always_comb begin
        unique case (mode_q)
            MODE_HALF: src_step = smod_q << 1;
            MODE_BYTE: src_step = (smod_q << 2) + (smod_q << 1);
            default:   src_step = smod_q;
        endcase
    end

    // map an internal index into the internal window
    function automatic logic [AW-1:0] to_window(input logic [AW-1:0] idx);
        logic [AW-1:0] low;
        low = '0;
        low[WIN_BIT-1:0] = idx[WIN_BIT-1:0];
        return low | WIN_BASE;
    endfunction

    // ---------------- packing of gathered words ----------------
    always_comb begin
        packed_w = '0;
        unique case (mode_q)
            MODE_HALF: begin
                packed_w[31:16] = slot_w[0][15:0];
                packed_w[15:0]  = slot_w[1][15:0];
            end
            MODE_BYTE: begin
                for (int k = 0; k < NSLOT; k++) begin
                    packed_w[8*k +: 8] = slot_w[k][7:0];
                end
            end
            default: packed_w[31:0] = slot_w[0][31:0];
        endcase
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok && !start_bad) begin
                    state_d = start_chain ? ST_DFETCH : ST_FETCH;
                end
            end
            ST_FETCH:  if (!stall && last_sub)  state_d = ST_DRAIN;
            ST_DRAIN:  if (!stall)              state_d = ST_WRITE;
            ST_WRITE: begin
                if (!stall) begin
                    if (!step_done)     state_d = ST_FETCH;
                    else if (more_desc) state_d = ST_DFETCH;
                    else                state_d = ST_IDLE;
                end
            end
            ST_DFETCH: if (!stall && dlast_sub) state_d = ST_DDRAIN;
            ST_DDRAIN: if (!stall)              state_d = ST_DLOAD;
            ST_DLOAD:  if (!stall)              state_d = ST_FETCH;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_WORD;
            tx_q      <= 1'b0;
            chained_q <= 1'b0;
            err_q     <= 1'b0;
            src_q     <= '0;
            dst_q     <= '0;
            smod_q    <= '0;
            dmod_q    <= '0;
            dbase_q   <= '0;
            cnt_q     <= '0;
            chain_q   <= '0;
            sub_q     <= '0;
        end else if (!stall) begin
            sub_q <= ((state_q == ST_FETCH && !last_sub) ||
                      (state_q == ST_DFETCH && !dlast_sub)) ? sub_q + 3'd1 : '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        err_q <= start_bad;
                        if (!start_bad) begin
                            mode_q    <= pk_mode_e'(cfg_mode);
                            tx_q      <= cfg_tx;
                            chained_q <= start_chain;
                            chain_q   <= '0;
                            cnt_q     <= cfg_count;
                            src_q     <= cfg_tx ? to_window(cfg_int_idx) : cfg_ext_idx;
                            dst_q     <= cfg_tx ? cfg_ext_idx : to_window(cfg_int_idx);
                            smod_q    <= cfg_tx ? cfg_int_mod : cfg_ext_mod;
                            dmod_q    <= cfg_tx ? cfg_ext_mod : cfg_int_mod;
                            dbase_q   <= to_window(cfg_chain);
                        end
                    end
                end
                ST_WRITE: begin
                    src_q <= src_q + src_step;
                    dst_q <= dst_q + dmod_q;
                    cnt_q <= cnt_next;
                    if (step_done && more_desc) begin
                        dbase_q   <= to_window(AW'(chain_q));
                        chained_q <= 1'b1;
                    end
                end
                ST_DLOAD: begin
                    src_q   <= tx_q ? to_window(slot_w[0][AW-1:0]) : slot_w[4][AW-1:0];
                    dst_q   <= tx_q ? slot_w[4][AW-1:0] : to_window(slot_w[0][AW-1:0]);
                    smod_q  <= tx_q ? slot_w[1][AW-1:0] : slot_w[5][AW-1:0];
                    dmod_q  <= tx_q ? slot_w[5][AW-1:0] : slot_w[1][AW-1:0];
                    cnt_q   <= slot_w[2][CW-1:0];
                    chain_q <= slot_w[3][PW-1:0];
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        raise_irq = 1'b0;
        if (!stall) begin
            unique case (state_q)
                ST_FETCH: begin
                    mem_req  = 1'b1;
                    mem_addr = src_q + AW'(sub_q);
                end
                ST_DFETCH: begin
                    mem_req  = 1'b1;
                    mem_addr = dbase_q - AW'(sub_q);
                end
                ST_WRITE: begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = dst_q;
                    mem_wdata = packed_w;
                    raise_irq = step_done && (!chained_q || chain_q[WIN_BIT]);
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign err  = err_q;

    // ---------------- sub-blocks ----------------
    pkdma_gather #(.DW(DW), .NSLOT(NSLOT), .SW(SLOT_W)) u_gather (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (mem_req && !mem_we),
        .slot       (sub_q),
        .rdata      (mem_rdata),
        .slots_flat (slots_flat)
    );

    pkdma_irq #(.IW(IW), .BIT(IRQ_BIT)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (raise_irq),
        .mask  (irq_mask[IRQ_BIT]),
        .clr   (irq_clr),
        .latch (irq_latch),
        .pend  (irq_pend)
    );

    logic unused_bits;
    assign unused_bits = ^{slots_flat, cfg_chain, cfg_int_idx, irq_mask};

    // ---------------- assertions ----------------
    // R8: a stalled cycle changes no channel state
    a_r8_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(state_q) && $stable(cnt_q) && $stable(src_q) && $stable(dst_q)));
    // R5: busy only drops on the edge of a final write
    a_r5_busy_falls_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mem_we));
    // R5: a write is always preceded by the drain of its reads
    a_r5_write_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(state_q) == ST_DRAIN || $past(state_q) == ST_WRITE));
    // R12: an error leaves the channel idle
    a_r12_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    // R10: descriptor words are read at descending addresses
    a_r10_desc_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DFETCH && mem_req && $past(state_q) == ST_DFETCH && $past(mem_req))
            |-> (mem_addr == $past(mem_addr) - AW'(1)));

endmodule

// File: tb/tb_pkdma_channel.sv
module tb_pkdma_channel;

    localparam int AW = 24;
    localparam int DW = 48;
    localparam int CW = 16;
    localparam int IW = 32;
    localparam logic [IW-1:0] IRQ_ONE = 32'h0000_0400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic          cfg_tx = 1'b0;
    logic [AW-1:0] cfg_int_idx = '0, cfg_int_mod = '0, cfg_ext_idx = '0, cfg_ext_mod = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [AW-1:0] cfg_chain = '0;
    logic          stall_dir = 1'b0, stall_rnd = 1'b0, rnd_en = 1'b0;
    logic          stall;
    logic [IW-1:0] irq_mask = '0;
    logic          irq_clr = 1'b0;
    logic          mem_req, mem_we, busy, err, irq_pend;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [IW-1:0] irq_latch;

    int checks = 0, failures = 0, stall_viol = 0, cyc = 0;
    logic [DW-1:0] mem [512];
    logic [DW-1:0] exp_mem [512];

    assign stall = stall_dir | stall_rnd;

    always #2 clk = ~clk;   // 250 MHz

    pkdma_channel #(.AW(AW), .DW(DW), .CW(CW), .IW(IW), .CH(0)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode), .cfg_tx(cfg_tx),
        .cfg_int_idx(cfg_int_idx), .cfg_int_mod(cfg_int_mod), .cfg_ext_idx(cfg_ext_idx),
        .cfg_ext_mod(cfg_ext_mod), .cfg_count(cfg_count), .cfg_chain(cfg_chain),
        .stall(stall), .irq_mask(irq_mask), .irq_clr(irq_clr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .err(err), .irq_latch(irq_latch), .irq_pend(irq_pend));

    function automatic int mi(input logic [AW-1:0] a);
        return int'({a[17], a[7:0]});
    endfunction

    // memory model: registered read data, one-cycle latency
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem[mi(mem_addr)];
        if (mem_req && mem_we)  mem[mi(mem_addr)] <= mem_wdata;
    end

    always @(negedge clk) begin
        stall_rnd <= rnd_en ? ($urandom % 4 == 0) : 1'b0;
        if (stall && mem_req) stall_viol++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = -1;
        for (int i = 0; i < 512; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            failures++;
            $display("FAIL %s mem[%0d] actual=%h expected=%h", req, bad, mem[bad], exp_mem[bad]);
        end
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d);
        mem[mi(a)] = d; exp_mem[mi(a)] = d;
    endtask

    task automatic launch(input int mode, input bit tx, input logic [AW-1:0] ii, im, ei, em,
                          input int cnt, input logic [AW-1:0] chain);
        @(negedge clk);
        cfg_mode = 2'(mode); cfg_tx = tx; cfg_int_idx = ii; cfg_int_mod = im;
        cfg_ext_idx = ei; cfg_ext_mod = em; cfg_count = CW'(cnt); cfg_chain = chain;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle;
        int t = 0;
        while (busy && t < 3000) begin @(negedge clk); t++; end
        if (t >= 3000) begin checks++; failures++; $display("FAIL wait_idle timeout"); end
    endtask

    task automatic ref_xfer(input int mode, input bit tx, input logic [AW-1:0] ii, im, ei, em,
                            input int cnt_in);
        logic [AW-1:0] ia, s, d, sm, dm;
        logic [DW-1:0] w;
        int n, cnt;
        cnt = cnt_in;
        ia = {6'd0, 1'b1, ii[16:0]};
        if (tx) begin s = ia; sm = im; d = ei; dm = em; end
        else    begin s = ei; sm = em; d = ia; dm = im; end
        n = (mode == 0) ? 1 : (mode == 1) ? 2 : 6;
        do begin
            w = '0;
            if (mode == 0) w[31:0] = exp_mem[mi(s)][31:0];
            else if (mode == 1) w[31:0] = {exp_mem[mi(s)][15:0], exp_mem[mi(s + 24'd1)][15:0]};
            else for (int k = 0; k < 6; k++) w[8*k +: 8] = exp_mem[mi(s + AW'(k))][7:0];
            exp_mem[mi(d)] = w;
            s = s + sm * AW'(n);
            d = d + dm;
            cnt = cnt - n;
        end while (cnt > 0);
    endtask

    task automatic ref_chain(input logic [AW-1:0] ptr_in, input int mode, input bit tx,
                             output bit irq);
        logic [AW-1:0] ptr, b, nx;
        ptr = ptr_in; irq = 1'b0;
        do begin
            b  = {6'd0, 1'b1, ptr[16:0]};
            nx = exp_mem[mi(b - 24'd3)][AW-1:0];
            ref_xfer(mode, tx, exp_mem[mi(b)][AW-1:0], exp_mem[mi(b - 24'd1)][AW-1:0],
                     exp_mem[mi(b - 24'd4)][AW-1:0], exp_mem[mi(b - 24'd5)][AW-1:0],
                     int'($signed(exp_mem[mi(b - 24'd2)][CW-1:0])));
            irq |= nx[17];
            ptr = nx;
        end while (ptr[16:0] != 17'd0);
    endtask

    task automatic put_desc(input logic [AW-1:0] ptr, input logic [AW-1:0] ii, im,
                            input int cnt, input logic [AW-1:0] nx, ei, em);
        logic [AW-1:0] b;
        b = {6'd0, 1'b1, ptr[16:0]};
        put(b, DW'(ii)); put(b - 24'd1, DW'(im)); put(b - 24'd2, DW'(cnt));
        put(b - 24'd3, DW'(nx)); put(b - 24'd4, DW'(ei)); put(b - 24'd5, DW'(em));
    endtask

    task automatic clear_irq;
        @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    endtask

    initial begin
        bit ex_irq;
        int n;
        void'($urandom(32'h5EED_0001));
        for (int i = 0; i < 512; i++) begin
            mem[i] = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset outputs", {busy, err, irq_pend, mem_req, irq_latch}, '0);
        rst_n = 1'b1;
        irq_mask = IRQ_ONE;

        // R2 no packing, rx, with interrupt (R9 mask on)
        launch(0, 0, 24'h000020, 24'd1, 24'h000010, 24'd1, 5, '0);
        ref_xfer(0, 0, 24'h000020, 24'd1, 24'h000010, 24'd1, 5);
        wait_idle; cmp_mem("R2 word copy");
        check("R9 latch bit with mask", 64'(irq_latch), 64'(IRQ_ONE));
        check("R9 pend with mask", 64'(irq_pend), 64'd1);
        clear_irq;
        check("R9 irq_clr clears", {irq_latch, irq_pend}, '0);

        // R3 halves, tx
        launch(1, 1, 24'h000030, 24'd1, 24'h000040, 24'd1, 6, '0);
        ref_xfer(1, 1, 24'h000030, 24'd1, 24'h000040, 24'd1, 6);
        wait_idle; cmp_mem("R3 half packing");

        // R4 bytes, rx, count 12
        launch(2, 0, 24'h000050, 24'd1, 24'h000008, 24'd1, 12, '0);
        ref_xfer(2, 0, 24'h000050, 24'd1, 24'h000008, 24'd1, 12);
        wait_idle; cmp_mem("R4 byte packing");

        // R5 count 7 in byte mode: two steps, 16 busy cycles
        launch(2, 1, 24'h000010, 24'd1, 24'h000060, 24'd1, 7, '0);
        ref_xfer(2, 1, 24'h000010, 24'd1, 24'h000060, 24'd1, 7);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
        check("R5 busy cycles", 64'(n), 64'd16);
        cmp_mem("R5 partial final step");

        // R6 negative modifiers
        launch(0, 1, 24'h000040, 24'hFFFFFF, 24'h000060, 24'hFFFFFE, 4, '0);
        ref_xfer(0, 1, 24'h000040, 24'hFFFFFF, 24'h000060, 24'hFFFFFE, 4);
        wait_idle; cmp_mem("R6 signed modifiers");

        // R7 index masking into the internal window
        launch(0, 0, 24'hFC0050, 24'd1, 24'h000070, 24'd1, 2, '0);
        ref_xfer(0, 0, 24'hFC0050, 24'd1, 24'h000070, 24'd1, 2);
        wait_idle; cmp_mem("R7 internal window mask");
        clear_irq;

        // R8 stall hold mid transfer
        launch(2, 0, 24'h000020, 24'd1, 24'h000030, 24'd1, 12, '0);
        ref_xfer(2, 0, 24'h000020, 24'd1, 24'h000030, 24'd1, 12);
        repeat (3) @(negedge clk);
        stall_dir = 1'b1;
        n = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_req || !busy) n++; end
        check("R8 frozen during stall", 64'(n), 64'd0);
        stall_dir = 1'b0;
        wait_idle; cmp_mem("R8 result after stall");
        // R8 start during stall is ignored
        stall_dir = 1'b1;
        launch(0, 0, 24'h000020, 24'd1, 24'h000010, 24'd1, 3, '0);
        @(negedge clk);
        check("R8 start ignored under stall", 64'(busy), 64'd0);
        stall_dir = 1'b0;
        @(negedge clk);
        check("R8 still idle after stall", 64'(busy), 64'd0);
        cmp_mem("R8 no write from dropped start");
        clear_irq;

        // R9 mask off: latch but no pend
        irq_mask = '0;
        launch(0, 0, 24'h000024, 24'd1, 24'h000014, 24'd1, 1, '0);
        ref_xfer(0, 0, 24'h000024, 24'd1, 24'h000014, 24'd1, 1);
        wait_idle;
        check("R9 latch without mask", 64'(irq_latch), 64'(IRQ_ONE));
        check("R9 no pend without mask", 64'(irq_pend), 64'd0);
        clear_irq;
        irq_mask = IRQ_ONE;

        // R10 R11 two-descriptor chain, last has bit 17
        put_desc(24'h0000F0, 24'h000040, 24'd1, 4, 24'h0000E0, 24'h000010, 24'd1);
        put_desc(24'h0000E0, 24'h000048, 24'd2, 6, 24'h020000, 24'h000030, 24'd1);
        launch(1, 0, 24'h0, 24'h0, 24'h0, 24'h0, 0, 24'h0000F0);
        ref_chain(24'h0000F0, 1, 0, ex_irq);
        wait_idle; cmp_mem("R10 chained descriptors");
        check("R11 irq from flagged link", 64'(irq_latch), ex_irq ? 64'(IRQ_ONE) : 64'd0);
        clear_irq;
        // R11 single descriptor without bit 17: no interrupt
        put_desc(24'h0000D0, 24'h000060, 24'd1, 3, 24'h000000, 24'h000050, 24'd1);
        launch(0, 1, 24'h0, 24'h0, 24'h0, 24'h0, 0, 24'h0200D0);
        ref_chain(24'h0000D0, 0, 1, ex_irq);
        wait_idle; cmp_mem("R10 single descriptor tx");
        check("R11 no irq without flag", 64'(irq_latch), 64'd0);

        // R12 invalid mode
        launch(3, 0, 24'h000020, 24'd1, 24'h000010, 24'd1, 4, '0);
        check("R12 err set", 64'(err), 64'd1);
        check("R12 stays idle", 64'(busy), 64'd0);
        cmp_mem("R12 no access");
        launch(0, 0, 24'h000020, 24'd1, 24'h000010, 24'd1, 1, '0);
        ref_xfer(0, 0, 24'h000020, 24'd1, 24'h000010, 24'd1, 1);
        check("R12 err cleared by valid start", 64'(err), 64'd0);
        wait_idle; cmp_mem("R12 valid after error");

        // R13 start while busy ignored
        launch(0, 0, 24'h000010, 24'd1, 24'h000040, 24'd1, 8, '0);
        ref_xfer(0, 0, 24'h000010, 24'd1, 24'h000040, 24'd1, 8);
        repeat (3) @(negedge clk);
        launch(1, 0, 24'h000070, 24'd1, 24'h000020, 24'd1, 4, '0);
        wait_idle; @(negedge clk);
        check("R13 no restart", 64'(busy), 64'd0);
        cmp_mem("R13 second start dropped");

        // random transfers with random stall (R2 R3 R4 R6 R7 R8)
        rnd_en = 1'b1;
        for (int it = 0; it < 24; it++) begin
            int md, cnt;
            bit tx;
            logic [AW-1:0] ii, ei, im, em;
            md = $urandom % 3; tx = 1'($urandom % 2); cnt = 1 + $urandom % 12;
            ii = AW'(32'h30 + $urandom % 32); ei = AW'(32'h30 + $urandom % 32);
            im = ($urandom % 2) ? AW'(1 + $urandom % 2) : -AW'(1 + $urandom % 2);
            em = ($urandom % 2) ? AW'(1 + $urandom % 2) : -AW'(1 + $urandom % 2);
            wait (!stall_rnd);
            launch(md, tx, ii, im, ei, em, cnt, '0);
            if (busy) ref_xfer(md, tx, ii, im, ei, em, cnt);
            wait_idle;
            cmp_mem("R2 R3 R4 R6 random transfer");
        end
        rnd_en = 1'b0;
        check("R8 no request while stalled", 64'(stall_viol), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule